// File: doc/BRIEF.md
# Status-Word Swapping Interrupt Unit

This unit holds the single 128-bit current status word of one processor. The low 64 bits are the address of the next instruction to fetch. The upper half carries the enable bits that gate interrupts. The unit does not jump through a vector table. It passes control by exchanging whole status words. Each of six interrupt classes owns an old-word slot and a new-word slot. Software preloads the new-word slot with its handler's status word.

Requests are latched per class as pending. When an enabled pending class is taken, the current word is saved into that class's old slot. The class's new word then becomes current, so the next fetch address is the handler's. A return operation reloads the current word from a chosen class's old slot. This restores the interrupted address and enable state. Software can also load new slots, load the current word directly and read back any slot.

Top module: `psw_swap_unit`

## Requirements
- R1: After reset the current word, every old and new slot and the pending vector are all zero, and `take_o` is low.
- R2: `fetch_addr` always equals bits [63:0] of the current word, and after a swap it equals the address field of the taken class's new word.
- R3: When class c is taken at a clock edge, old slot c holds the current word from just before that edge, and the current word becomes new slot c.
- R4: Classes are indexed 0 = machine check, 1 = program, 2 = external, 3 = I/O, 4 and 5 = auxiliary. When several classes are eligible, the lowest index is taken.
- R5: Current-word bit 64+k enables class k for k = 0..3. Classes 4 and 5 are always enabled. A pending request of a disabled class is not taken and stays pending.
- R6: A high `irq` bit sets that class's pending bit at the next edge. A pending bit clears only at the edge where its class is taken, unless a new request for that class arrives at the same edge.
- R7: Writing a new slot stores `ld_word` with bits [67:64] forced to zero, so a handler starts with classes 0 to 3 masked.
- R8: A swap completes at one edge. `take_o` is high, with `take_cls_o` naming the class, for the following cycle. No class is taken at the edge that ends that cycle.
- R9: A return with `ret_cls` = c loads old slot c into the current word at the next edge. A return takes precedence over a direct load, and both defer any take in that cycle.
- R10: `ld_cur` writes `ld_word` unchanged into the current word at the next edge.
- R11: `rd_word` shows old slot `rd_cls` when `rd_old` is 1, and new slot `rd_cls` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 6 | Interrupt request per class |
| ld_new | input | 1 | Write new slot `ld_cls` |
| ld_cur | input | 1 | Write current word |
| ld_cls | input | 3 | Class selected for new-slot write |
| ld_word | input | 128 | Data for slot or current-word write |
| ret | input | 1 | Return from interrupt |
| ret_cls | input | 3 | Class whose old slot is restored |
| rd_old | input | 1 | Read selects old slot (1) or new slot (0) |
| rd_cls | input | 3 | Class selected for read |
| rd_word | output | 128 | Selected slot contents |
| cur_word | output | 128 | Current status word |
| fetch_addr | output | 64 | Next instruction address |
| pending | output | 6 | Latched pending requests |
| take_o | output | 1 | A swap happened at the previous edge |
| take_cls_o | output | 3 | Class of the last swap |

## Verification
Directed patterns come first. All six requests are raised together with every class enabled. This separates the priority order from arrival order. The same requests are then raised with classes 0 to 3 masked. This separates "kept pending" from "dropped" and from "taken anyway". A new slot is loaded with its enable bits set to show that the write clears them. A take and a return are placed back to back to show whether the old slot really holds the interrupted word. Random traffic then mixes sparse requests with slot loads, direct loads and returns. This exposes ordering faults: a take that collides with a return or a direct load, a request arriving at the edge its class is taken, and a take attempted during the cycle after a swap.

// File: rtl/psw_swap_unit.sv
module psw_swap_unit #(
  parameter int W      = 128,
  parameter int AW     = 64,
  parameter int NCLS   = 6,
  parameter int EN_LSB = 64,
  parameter int NEN    = 4,
  parameter int CW     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] irq,
  input  logic            ld_new,
  input  logic            ld_cur,
  input  logic [CW-1:0]   ld_cls,
  input  logic [W-1:0]    ld_word,
  input  logic            ret,
  input  logic [CW-1:0]   ret_cls,
  input  logic            rd_old,
  input  logic [CW-1:0]   rd_cls,
  output logic [W-1:0]    rd_word,
  output logic [W-1:0]    cur_word,
  output logic [AW-1:0]   fetch_addr,
  output logic [NCLS-1:0] pending,
  output logic            take_o,
  output logic [CW-1:0]   take_cls_o
);

  logic [W-1:0]    cur_q;
  logic [W-1:0]    old_q [NCLS];
  logic [W-1:0]    new_q [NCLS];
  logic [NCLS-1:0] pend_q, en_mask, elig, grant;
  logic [CW-1:0]   gcls, take_cls_q;
  logic            take_q, go;
  logic [W-1:0]    ret_src, masked_word;

  genvar k;
  generate
    for (k = 0; k < NCLS; k++) begin : g_en
      if (k < NEN) begin : g_bit
        assign en_mask[k] = cur_q[EN_LSB+k];
      end else begin : g_always
        assign en_mask[k] = 1'b1;
      end
    end
  endgenerate

  assign elig = pend_q & en_mask;

  always_comb begin
    gcls  = '0;
    grant = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        gcls  = CW'(i);
        grant = NCLS'(1) << i;
      end
    end
  end

  assign go = (|elig) && !take_q && !ret && !ld_cur;

  assign ret_src = (int'(ret_cls) < NCLS) ? old_q[ret_cls] : cur_q;

  always_comb begin
    masked_word = ld_word;
    masked_word[EN_LSB +: NEN] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      pend_q     <= '0;
      take_q     <= 1'b0;
      take_cls_q <= '0;
      for (int i = 0; i < NCLS; i++) begin
        old_q[i] <= '0;
        new_q[i] <= '0;
      end
    end else begin
      pend_q <= (pend_q & ~(go ? grant : '0)) | irq;
      take_q <= go;
      if (go) take_cls_q <= gcls;
      if (ret) cur_q <= ret_src;
      else if (ld_cur) cur_q <= ld_word;
      else if (go) cur_q <= new_q[gcls];
      if (go) old_q[gcls] <= cur_q;
      if (ld_new && int'(ld_cls) < NCLS) new_q[ld_cls] <= masked_word;
    end
  end

  assign rd_word    = (int'(rd_cls) >= NCLS) ? '0 : (rd_old ? old_q[rd_cls] : new_q[rd_cls]);
  assign cur_word   = cur_q;
  assign fetch_addr = cur_q[AW-1:0];
  assign pending    = pend_q;
  assign take_o     = take_q;
  assign take_cls_o = take_cls_q;

  a_r3_old_saved: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> old_q[take_cls_q] == $past(cur_q));

  a_r7_handler_masked: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> cur_q[EN_LSB +: NEN] == '0);

  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);

  a_r5_disabled_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(pend_q & ~en_mask)) == $past(pend_q & ~en_mask));

  a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && int'(ret_cls) < NCLS) |=> cur_q == $past(ret_src));

  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ($onehot0(grant) && (elig & (grant - NCLS'(1))) == '0));

endmodule

// File: tb/sim_psw_swap_unit.sv
module sim_psw_swap_unit;
  localparam int W = 128, NCLS = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] irq = '0;
  logic ld_new = 0, ld_cur = 0, ret = 0, rd_old = 0;
  logic [2:0] ld_cls = '0, ret_cls = '0, rd_cls = '0;
  logic [W-1:0] ld_word = '0;
  logic [W-1:0] rd_word, cur_word;
  logic [63:0] fetch_addr;
  logic [5:0] pending;
  logic take_o;
  logic [2:0] take_cls_o;

  psw_swap_unit u0 (.clk, .rst_n, .irq, .ld_new, .ld_cur, .ld_cls, .ld_word,
    .ret, .ret_cls, .rd_old, .rd_cls, .rd_word, .cur_word, .fetch_addr,
    .pending, .take_o, .take_cls_o);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [W-1:0] m_cur, m_old [NCLS], m_new [NCLS];
  logic [5:0] m_pend;
  logic m_take;
  logic [2:0] m_tcls;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] en_of(input logic [W-1:0] w);
    return {2'b11, w[67:64]};
  endfunction

  function automatic int pick(input logic [5:0] e);
    for (int i = 0; i < NCLS; i++) if (e[i]) return i;
    return -1;
  endfunction

  function automatic logic [W-1:0] mask_en(input logic [W-1:0] w);
    logic [W-1:0] r = w;
    r[67:64] = '0;
    return r;
  endfunction

  task automatic step();
    logic [W-1:0] n_cur;
    logic [5:0] n_pend;
    int g;
    bit go;
    g  = pick(m_pend & en_of(m_cur));
    go = (g >= 0) && !m_take && !ret && !ld_cur;
    n_pend = m_pend | irq;
    if (go) n_pend = (m_pend & ~(6'd1 << g)) | irq;
    n_cur = m_cur;
    if (ret) n_cur = m_old[ret_cls];
    else if (ld_cur) n_cur = ld_word;
    else if (go) n_cur = m_new[g];
    @(posedge clk);
    @(negedge clk);
    if (go) begin m_old[g] = m_cur; m_tcls = 3'(g); end
    if (ld_new) m_new[ld_cls] = mask_en(ld_word);
    m_cur = n_cur; m_pend = n_pend; m_take = go;
    chk("R3/R9/R10 cur_word", cur_word, m_cur);
    chk("R2 fetch_addr", W'(fetch_addr), W'(m_cur[63:0]));
    chk("R5/R6 pending", W'(pending), W'(m_pend));
    chk("R8 take_o", W'(take_o), W'(m_take));
    if (m_take) chk("R4 take_cls_o", W'(take_cls_o), W'(m_tcls));
  endtask

  task automatic idle();
    irq = '0; ld_new = 0; ld_cur = 0; ret = 0;
  endtask

  task automatic rd_check(input logic o, input logic [2:0] c);
    rd_old = o; rd_cls = c; #1;
    chk("R11 rd_word", rd_word, o ? m_old[c] : m_new[c]);
  endtask

  function automatic logic [W-1:0] rword();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7121));
    m_cur = '0; m_pend = '0; m_take = 0; m_tcls = '0;
    for (int i = 0; i < NCLS; i++) begin m_old[i] = '0; m_new[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    chk("R1 cur_word", cur_word, '0);
    chk("R1 pending", W'(pending), '0);
    chk("R1 take_o", W'(take_o), '0);
    for (int i = 0; i < NCLS; i++) begin rd_check(1, 3'(i)); rd_check(0, 3'(i)); end

    // R7: load handlers with enable bits set; they must be cleared
    for (int i = 0; i < NCLS; i++) begin
      idle(); ld_new = 1; ld_cls = 3'(i);
      ld_word = {60'h0, 4'hF, 64'h1000 * (i + 1)};
      step();
      rd_old = 0; rd_cls = 3'(i); #1;
      chk("R7 new slot enables cleared", W'(rd_word[67:64]), '0);
    end
    // R10: enable everything
    idle(); ld_cur = 1; ld_word = {60'hABC, 4'hF, 64'h0000_0000_DEAD_0000}; step();
    // R4: all six at once -> machine check first
    idle(); irq = 6'h3F; step();
    idle(); step();
    chk("R4 first taken is class 0", W'(take_cls_o), W'(0));
    chk("R2 handler address", W'(fetch_addr), W'(64'h1000));
    rd_check(1, 3'd0);
    chk("R3 old slot holds interrupted word", rd_word, {60'hABC, 4'hF, 64'h0000_0000_DEAD_0000});
    // R5: classes 1..3 masked now; 4 then 5 taken, 1..3 remain pending
    for (int i = 0; i < 6; i++) step();
    chk("R5 masked classes stay pending", W'(pending), W'(6'b001110));
    // R9: return from class 0 restores enables; class 1 next
    idle(); ret = 1; ret_cls = 3'd0; step();
    chk("R9 restored address", W'(fetch_addr), W'(64'hDEAD_0000));
    idle(); step();
    chk("R4 program class next", W'(take_cls_o), W'(1));

    // random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 4 == 0) irq = 6'd1 << ($urandom % 6);
      if ($urandom % 8 == 0) begin ld_new = 1; ld_cls = 3'($urandom % 6); end
      if ($urandom % 16 == 0) ld_cur = 1;
      ld_word = rword();
      if ($urandom % 14 == 0) begin ret = 1; ret_cls = 3'($urandom % 6); end
      step();
      if (n % 10 == 0) rd_check(1'($urandom), 3'($urandom % 6));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule